// File: doc/BRIEF.md
# Bus Transfer Wait-State Profiler

This block watches an APB bus without driving it and prices every transfer. It sees the setup cycle, counts the access cycles the completer stalls with PREADY low, and when the completing access cycle arrives it reports the wait count N and the total latency. The reported latency is always two more than N.

The address seen in the setup cycle decides the transfer's address region. Each region has its own mask, base and wait budget. For each region, including a default region for addresses that match none, the block keeps a histogram of wait counts, the largest N seen and a count of transfers that went over budget. A transfer that goes over budget raises a one-cycle pulse together with its result.

The block is meant to be instantiated beside a peripheral bus in a verification or performance build. From its outputs, slow completers can be found by address region without post-processing a trace. All counters saturate instead of wrapping.

Top module: `apb_wait_profiler`

## Requirements
- R1: One clock edge after the edge that samples the completing access cycle, `doneValid` is high for exactly one cycle, and `doneRegion`, `doneWaits` and `doneLatency` carry that transfer's result.
- R2: `doneWaits` equals the number of sampled access cycles (PSEL and PENABLE high) with PREADY low that came between the setup cycle and the completion.
- R3: `doneLatency` equals `doneWaits` + 2. The setup cycle counts once, each wait cycle counts once and the completion cycle counts once.
- R4: A completer with no wait states gives `doneLatency` = 2, and no reported latency is ever below 2.
- R5: The region is chosen from the address sampled in the setup cycle. Region k matches when (address AND mask[k]) equals base[k]. When several regions match, the lowest index wins. An address that matches none goes to the default index NUM_REGIONS. Changes to the address during the access phase have no effect.
- R6: Each completion adds one to bin min(N, BINS-1) of its region's histogram, at the same edge that raises `doneValid`. `histBins[r][b]` is region r, bin b.
- R7: `worstWaits[r]` holds the largest N completed in region r since reset or clear.
- R8: When N is strictly greater than `regionBudget[r]`, `overBudget` pulses together with `doneValid` and `violCount[r]` goes up by one. When N equals the budget, nothing is flagged.
- R9: A setup cycle while a transfer is still open drops the open measurement, which is then never reported or counted, and sets the sticky `anomaly` output. The new transfer is measured normally.
- R10: A high `clear` at a clock edge zeroes all histograms, worst-case values, violation counts, `anomaly` and any open measurement.
- R11: After the asynchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of all statistics |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus enable (access phase) |
| pready | input | 1 | Completer ready |
| paddr | input | ADDR_W | Bus address |
| regionBase | input | NUM_REGIONS x ADDR_W | Base address of each region |
| regionMask | input | NUM_REGIONS x ADDR_W | Compare mask of each region |
| regionBudget | input | (NUM_REGIONS+1) x CNT_W | Wait budget of each region, default region last |
| doneValid | output | 1 | One-cycle result strobe |
| doneRegion | output | clog2(NUM_REGIONS+1) | Region of the finished transfer |
| doneWaits | output | CNT_W | Wait count N |
| doneLatency | output | CNT_W | Total cycles, N + 2 |
| overBudget | output | 1 | Pulse: N exceeded the region budget |
| histBins | output | (NUM_REGIONS+1) x BINS x HIST_W | Wait-count histograms |
| worstWaits | output | (NUM_REGIONS+1) x CNT_W | Largest N per region |
| violCount | output | (NUM_REGIONS+1) x HIST_W | Over-budget transfers per region |
| anomaly | output | 1 | Sticky: setup seen while a transfer was open |

## Verification
The bench uses four regions, eight bins and a 16-bit address. Two of the region windows overlap on purpose, so that the priority rule is exercised. Every region, including the default one, gets every wait count from 0 to 9. This reaches the zero-wait floor, each budget exactly at and one past its limit, and the shared top bin that collects N of 7 and above. Separate sequences cover an aborted measurement followed by a fresh transfer, and a clear followed by new traffic.

// File: rtl/apb_prof_pkg.sv
`timescale 1ns/1ps
package apb_prof_pkg;
  typedef struct packed {
    logic clear;
    logic start;
    logic waitTick;
    logic finish;
  } profCtrl_t;
endpackage

// File: rtl/apb_prof_ctrl.sv
`timescale 1ns/1ps
module apb_prof_ctrl
  import apb_prof_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clear,
  input  logic      psel,
  input  logic      penable,
  input  logic      pready,
  output profCtrl_t ctrl,
  output logic      anomaly
);
  logic xferOpen;
  logic setupCyc;
  logic accessCyc;

  assign setupCyc  = psel && !penable;
  assign accessCyc = psel && penable && xferOpen;

  always_comb begin
    ctrl.clear    = clear;
    ctrl.start    = setupCyc && !clear;
    ctrl.waitTick = accessCyc && !pready && !clear;
    ctrl.finish   = accessCyc && pready && !clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferOpen <= 1'b0;
      anomaly  <= 1'b0;
    end else if (clear) begin
      xferOpen <= 1'b0;
      anomaly  <= 1'b0;
    end else begin
      if (setupCyc && xferOpen) anomaly <= 1'b1;
      if (ctrl.start)       xferOpen <= 1'b1;
      else if (ctrl.finish) xferOpen <= 1'b0;
    end
  end
endmodule

// File: rtl/apb_prof_dp.sv
`timescale 1ns/1ps
module apb_prof_dp
  import apb_prof_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BINS        = 8,
  parameter int HIST_W      = 16
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  profCtrl_t                              ctrl,
  input  logic [ADDR_W-1:0]                      paddr,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]     regionBase,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]     regionMask,
  input  logic [NUM_REGIONS:0][CNT_W-1:0]        regionBudget,
  output logic                                   doneValid,
  output logic [$clog2(NUM_REGIONS+1)-1:0]       doneRegion,
  output logic [CNT_W-1:0]                       doneWaits,
  output logic [CNT_W-1:0]                       doneLatency,
  output logic                                   overBudget,
  output logic [NUM_REGIONS:0][BINS-1:0][HIST_W-1:0] histBins,
  output logic [NUM_REGIONS:0][CNT_W-1:0]        worstWaits,
  output logic [NUM_REGIONS:0][HIST_W-1:0]       violCount
);
  localparam int REG_W = $clog2(NUM_REGIONS + 1);
  localparam int BIN_W = $clog2(BINS);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [HIST_W-1:0] HIST_MAX = {HIST_W{1'b1}};

  logic [NUM_REGIONS-1:0] matchVec;
  logic [REG_W-1:0]       hitRegion;
  logic [REG_W-1:0]       curRegion;
  logic [CNT_W-1:0]       latCnt, waitCnt, latNext, waitNext;
  logic [BIN_W-1:0]       binSel;
  logic                   overNow;

  for (genvar k = 0; k < NUM_REGIONS; k++) begin : gMatch
    assign matchVec[k] = ((paddr & regionMask[k]) == regionBase[k]);
  end

  always_comb begin
    hitRegion = REG_W'(NUM_REGIONS);
    for (int k = NUM_REGIONS - 1; k >= 0; k--) begin
      if (matchVec[k]) hitRegion = REG_W'(k);
    end
  end

  assign latNext  = (latCnt == CNT_MAX)  ? latCnt  : latCnt + 1'b1;
  assign waitNext = (waitCnt == CNT_MAX) ? waitCnt : waitCnt + 1'b1;
  assign binSel   = (waitCnt >= CNT_W'(BINS - 1)) ? BIN_W'(BINS - 1)
                                                  : waitCnt[BIN_W-1:0];
  assign overNow  = ctrl.finish && (waitCnt > regionBudget[curRegion]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRegion   <= '0;
      latCnt      <= '0;
      waitCnt     <= '0;
      doneValid   <= 1'b0;
      doneRegion  <= '0;
      doneWaits   <= '0;
      doneLatency <= '0;
      overBudget  <= 1'b0;
      histBins    <= '0;
      worstWaits  <= '0;
      violCount   <= '0;
    end else if (ctrl.clear) begin
      curRegion   <= '0;
      latCnt      <= '0;
      waitCnt     <= '0;
      doneValid   <= 1'b0;
      doneRegion  <= '0;
      doneWaits   <= '0;
      doneLatency <= '0;
      overBudget  <= 1'b0;
      histBins    <= '0;
      worstWaits  <= '0;
      violCount   <= '0;
    end else begin
      doneValid  <= ctrl.finish;
      overBudget <= overNow;
      if (ctrl.start) begin
        curRegion <= hitRegion;
        latCnt    <= CNT_W'(1);
        waitCnt   <= '0;
      end else if (ctrl.waitTick) begin
        latCnt  <= latNext;
        waitCnt <= waitNext;
      end
      if (ctrl.finish) begin
        doneRegion  <= curRegion;
        doneWaits   <= waitCnt;
        doneLatency <= latNext;
        if (histBins[curRegion][binSel] != HIST_MAX)
          histBins[curRegion][binSel] <= histBins[curRegion][binSel] + 1'b1;
        if (waitCnt > worstWaits[curRegion])
          worstWaits[curRegion] <= waitCnt;
        if (overNow && (violCount[curRegion] != HIST_MAX))
          violCount[curRegion] <= violCount[curRegion] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/apb_wait_profiler.sv
`timescale 1ns/1ps
module apb_wait_profiler
  import apb_prof_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BINS        = 8,
  parameter int HIST_W      = 16
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   clear,
  input  logic                                   psel,
  input  logic                                   penable,
  input  logic                                   pready,
  input  logic [ADDR_W-1:0]                      paddr,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]     regionBase,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]     regionMask,
  input  logic [NUM_REGIONS:0][CNT_W-1:0]        regionBudget,
  output logic                                   doneValid,
  output logic [$clog2(NUM_REGIONS+1)-1:0]       doneRegion,
  output logic [CNT_W-1:0]                       doneWaits,
  output logic [CNT_W-1:0]                       doneLatency,
  output logic                                   overBudget,
  output logic [NUM_REGIONS:0][BINS-1:0][HIST_W-1:0] histBins,
  output logic [NUM_REGIONS:0][CNT_W-1:0]        worstWaits,
  output logic [NUM_REGIONS:0][HIST_W-1:0]       violCount,
  output logic                                   anomaly
);
  profCtrl_t ctrl;

  apb_prof_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear), .psel(psel), .penable(penable),
    .pready(pready), .ctrl(ctrl), .anomaly(anomaly)
  );

  apb_prof_dp #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .BINS(BINS), .HIST_W(HIST_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .paddr(paddr),
    .regionBase(regionBase), .regionMask(regionMask), .regionBudget(regionBudget),
    .doneValid(doneValid), .doneRegion(doneRegion), .doneWaits(doneWaits),
    .doneLatency(doneLatency), .overBudget(overBudget), .histBins(histBins),
    .worstWaits(worstWaits), .violCount(violCount)
  );
endmodule

// File: rtl/apb_prof_checker.sv
`timescale 1ns/1ps
module apb_prof_checker #(
  parameter int NUM_REGIONS = 4,
  parameter int CNT_W       = 16
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             clear,
  input logic                             doneValid,
  input logic [$clog2(NUM_REGIONS+1)-1:0] doneRegion,
  input logic [CNT_W-1:0]                 doneWaits,
  input logic [CNT_W-1:0]                 doneLatency,
  input logic                             overBudget,
  input logic [NUM_REGIONS:0][CNT_W-1:0]  regionBudget,
  input logic [NUM_REGIONS:0][CNT_W-1:0]  worstWaits,
  input logic                             anomaly
);
  localparam logic [CNT_W-1:0] SUM_LIMIT = {CNT_W{1'b1}} - CNT_W'(1);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R1
  AST_LAT_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneWaits < SUM_LIMIT) |-> (doneLatency == doneWaits + CNT_W'(2))); // R3
  AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneLatency >= CNT_W'(2))); // R4
  AST_WORST_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (worstWaits[doneRegion] >= doneWaits)); // R7
  AST_OVER_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    overBudget |-> doneValid); // R8
  AST_OVER_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (overBudget == (doneWaits > regionBudget[doneRegion]))); // R8
  AST_ANOMALY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (anomaly && !clear) |=> anomaly); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!anomaly && !doneValid)); // R10
endmodule

bind apb_wait_profiler apb_prof_checker #(
  .NUM_REGIONS(NUM_REGIONS), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .clear(clear), .doneValid(doneValid),
  .doneRegion(doneRegion), .doneWaits(doneWaits), .doneLatency(doneLatency),
  .overBudget(overBudget), .regionBudget(regionBudget), .worstWaits(worstWaits),
  .anomaly(anomaly)
);

// File: tb/apb_wait_profiler_test.sv
`timescale 1ns/1ps
module apb_wait_profiler_test;
  localparam int NR = 4;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int NB = 8;
  localparam int HW = 16;
  localparam int SLOTS = NR + 1;

  logic clk = 1'b0;
  logic rstN, clear, psel, penable, pready;
  logic [AW-1:0] paddr;
  logic [NR-1:0][AW-1:0] regionBase, regionMask;
  logic [NR:0][CW-1:0] regionBudget;
  logic doneValid, overBudget, anomaly;
  logic [$clog2(NR+1)-1:0] doneRegion;
  logic [CW-1:0] doneWaits, doneLatency;
  logic [NR:0][NB-1:0][HW-1:0] histBins;
  logic [NR:0][CW-1:0] worstWaits;
  logic [NR:0][HW-1:0] violCount;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  int expHist [SLOTS][NB];
  int expWorst [SLOTS];
  int expViol [SLOTS];
  logic [AW-1:0] regAddr [SLOTS];

  always #4 clk = ~clk;

  apb_wait_profiler #(.NUM_REGIONS(NR), .ADDR_W(AW), .CNT_W(CW), .BINS(NB), .HIST_W(HW)) uut (
    .clk(clk), .rstN(rstN), .clear(clear), .psel(psel), .penable(penable),
    .pready(pready), .paddr(paddr), .regionBase(regionBase), .regionMask(regionMask),
    .regionBudget(regionBudget), .doneValid(doneValid), .doneRegion(doneRegion),
    .doneWaits(doneWaits), .doneLatency(doneLatency), .overBudget(overBudget),
    .histBins(histBins), .worstWaits(worstWaits), .violCount(violCount), .anomaly(anomaly)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int r = 0; r < SLOTS; r++) begin
      expWorst[r] = 0;
      expViol[r] = 0;
      for (int b = 0; b < NB; b++) expHist[r][b] = 0;
    end
  endtask

  task automatic checkStats(input string req);
    for (int r = 0; r < SLOTS; r++) begin
      for (int b = 0; b < NB; b++)
        chk(histBins[r][b] == HW'(expHist[r][b]), {req, " hist"}, histBins[r][b], expHist[r][b]);
      chk(worstWaits[r] == CW'(expWorst[r]), {req, " worst"}, worstWaits[r], expWorst[r]);
      chk(violCount[r] == HW'(expViol[r]), {req, " viol"}, violCount[r], expViol[r]);
    end
  endtask

  // Drives one transfer with n wait cycles and checks the result strobe.
  task automatic runXfer(input logic [AW-1:0] addr, input int n, input int expReg);
    int bin;
    bit over;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pready = 1'b0; paddr = addr;
    @(negedge clk);
    penable = 1'b1; pready = (n == 0); paddr = ~addr; // R5: address moved in access phase
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(doneValid == 1'b0, "R1 no early strobe", doneValid, 0);
      if (i == n - 1) pready = 1'b1;
    end
    @(negedge clk);
    bin = (n > NB - 1) ? NB - 1 : n;
    over = (n > int'(regionBudget[expReg]));
    expHist[expReg][bin]++;
    if (n > expWorst[expReg]) expWorst[expReg] = n;
    if (over) expViol[expReg]++;
    chk(doneValid == 1'b1, "R1 strobe", doneValid, 1);
    chk(doneRegion == 3'(expReg), "R5 region", doneRegion, expReg);
    chk(doneWaits == CW'(n), "R2 waits", doneWaits, n);
    chk(doneLatency == CW'(n + 2), n == 0 ? "R4 floor" : "R3 latency", doneLatency, n + 2);
    chk(overBudget == over, "R8 pulse", overBudget, over);
    chk(histBins[expReg][bin] == HW'(expHist[expReg][bin]), "R6 bin", histBins[expReg][bin], expHist[expReg][bin]);
    chk(worstWaits[expReg] == CW'(expWorst[expReg]), "R7 worst", worstWaits[expReg], expWorst[expReg]);
    chk(violCount[expReg] == HW'(expViol[expReg]), "R8 count", violCount[expReg], expViol[expReg]);
    psel = 1'b0; penable = 1'b0; pready = 1'b0; paddr = '0;
    @(negedge clk);
    chk(doneValid == 1'b0 && overBudget == 1'b0, "R1 single pulse", doneValid, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clear = 1'b0; psel = 1'b0; penable = 1'b0; pready = 1'b0; paddr = '0;
    // Slot 0 is a narrow window inside slot 1, so 0x11xx matches both.
    regionMask[0] = 16'hFF00; regionBase[0] = 16'h1100;
    regionMask[1] = 16'hF000; regionBase[1] = 16'h1000;
    regionMask[2] = 16'hF000; regionBase[2] = 16'h2000;
    regionMask[3] = 16'hF000; regionBase[3] = 16'h3000;
    for (int r = 0; r < SLOTS; r++) regionBudget[r] = CW'(r + 1);
    regAddr[0] = 16'h1180; regAddr[1] = 16'h1280; regAddr[2] = 16'h2040;
    regAddr[3] = 16'h3FF0; regAddr[4] = 16'h7000;
    modelReset();
    repeat (3) @(negedge clk);
    chk(doneValid == 0 && anomaly == 0 && overBudget == 0, "R11 reset flags", doneValid, 0);
    checkStats("R11 reset");
    rstN = 1'b1;
    @(negedge clk);

    for (int r = 0; r < SLOTS; r++)
      for (int n = 0; n < 10; n++) runXfer(regAddr[r], n, r);
    checkStats("R6 sweep");
    chk(anomaly == 1'b0, "R9 no anomaly yet", anomaly, 0);

    // R9: abort an open transfer to slot 2 with a new setup to slot 3.
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; paddr = regAddr[2];
    @(negedge clk);
    penable = 1'b1; pready = 1'b0;
    repeat (2) @(negedge clk);
    penable = 1'b0; paddr = regAddr[3];
    @(negedge clk);
    chk(anomaly == 1'b1, "R9 anomaly set", anomaly, 1);
    chk(doneValid == 1'b0, "R9 no report of aborted", doneValid, 0);
    penable = 1'b1; pready = 1'b0; paddr = '0;
    @(negedge clk);
    pready = 1'b1;
    @(negedge clk);
    expHist[3][1]++;
    chk(doneValid == 1'b1 && doneRegion == 3'd3, "R9 new transfer region", doneRegion, 3);
    chk(doneWaits == 1 && doneLatency == 3, "R9 new transfer waits", doneWaits, 1);
    psel = 1'b0; penable = 1'b0; pready = 1'b0;
    @(negedge clk);
    checkStats("R9 aborted not counted");
    chk(anomaly == 1'b1, "R9 sticky", anomaly, 1);

    // R10: clear, then new traffic counts from zero.
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    modelReset();
    chk(anomaly == 1'b0, "R10 anomaly cleared", anomaly, 0);
    checkStats("R10 cleared");
    runXfer(regAddr[1], 3, 1);
    checkStats("R10 after clear");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule